// File: doc/BRIEF.md
# DMA Transfer Bus-Cycle Sequencer

This block carries out a single DMA move on a 16-bit memory bus. A start pulse captures a source address, a destination address, a unit size (one byte or one halfword) and a wait-state count. The block then reads the unit from the source and writes it to the destination. All read bus cycles finish before the first write bus cycle starts.

A halfword at an odd byte address cannot use both byte lanes in one access. In that case the block splits the access into two byte cycles. This is decided separately for the read side and the write side. Each bus cycle lasts one clock plus the programmed number of wait states. The bytes that are read are collected in a 16-bit holding register, so the write side can place them on whatever lanes the destination alignment needs. A one-clock done pulse marks the end of the transfer.

Top module: `dma_xfer_seq`

## Requirements
- R1: All read cycles of a transfer (`bus_we_o`=0) come before any of its write cycles (`bus_we_o`=1). A read cycle never directly follows a write cycle.
- R2: For a halfword at an even address, that side takes exactly one bus cycle on that address, with `bus_be_o`=2'b11 (bit 0 enables bits 7:0, the even byte; bit 1 enables bits 15:8, the odd byte).
- R3: For a halfword at an odd address A, that side takes two cycles. The first is at A with `bus_be_o`=2'b10 and moves the low byte of the unit on bits 15:8. The second is at A+1 with `bus_be_o`=2'b01 and moves the high byte on bits 7:0.
- R4: The split decision is made separately for the source and for the destination. For a halfword, the number of read cycles depends only on bit 0 of the source address, and the number of write cycles depends only on bit 0 of the destination address.
- R5: A byte unit takes one read cycle and one write cycle at the given address, on the lane chosen by address bit 0 (2'b01 when even, 2'b10 when odd). At the destination, only that byte changes.
- R6: With wait count N (0 to 3), every bus cycle keeps its address, lanes and direction steady for exactly 1+N clocks. Read data is sampled in the last of these clocks, and the write takes effect in that clock.
- R7: `done_o` is high for exactly one clock, in the clock right after the last write clock.
- R8: A start that arrives while a transfer is in progress, including the done clock, is ignored: it causes no extra bus cycle and no extra done pulse.
- R9: After a transfer, `rd_data_o` holds the unit that was read. For a halfword at source A this is {byte at A+1, byte at A}; for a byte unit it is the byte zero-extended.
- R10: After reset, `bus_req_o` and `done_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a transfer (sampled only when idle) |
| src_addr_i | input | AW | Source byte address |
| dst_addr_i | input | AW | Destination byte address |
| unit16_i | input | 1 | 1: halfword unit, 0: byte unit |
| wait_i | input | WW | Wait states added to each bus cycle |
| bus_req_o | output | 1 | Bus cycle in progress |
| bus_we_o | output | 1 | 1: write cycle, 0: read cycle |
| bus_addr_o | output | AW | Byte address of the current cycle |
| bus_be_o | output | 2 | Byte-lane enables (bit 0 = bits 7:0) |
| bus_wdata_o | output | 16 | Write data |
| bus_rdata_i | input | 16 | Read data from memory |
| rd_data_o | output | 16 | Holding register with the unit that was read |
| done_o | output | 1 | One-clock end-of-transfer pulse |

## Verification
The hardest case to reach from the ports is a read sampled too early or too late inside a stretched cycle, because a normal memory returns the same value on every clock. To expose it, the bench memory model counts the clocks of each bus cycle and returns the real data only on the final clock; on every other clock it returns the inverted data. The sweep covers every combination of unit size, source and destination parity, and wait count. Extra start pulses are fired both in the middle of a transfer and in the done clock.

// File: rtl/dma_xfer_seq.sv
module dma_xfer_seq #(
  parameter int AW = 16,
  parameter int WW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [AW-1:0] src_addr_i,
  input  logic [AW-1:0] dst_addr_i,
  input  logic          unit16_i,
  input  logic [WW-1:0] wait_i,
  output logic          bus_req_o,
  output logic          bus_we_o,
  output logic [AW-1:0] bus_addr_o,
  output logic [1:0]    bus_be_o,
  output logic [15:0]   bus_wdata_o,
  input  logic [15:0]   bus_rdata_i,
  output logic [15:0]   rd_data_o,
  output logic          done_o
);
  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR, S_DONE} st_t;

  st_t           st;
  logic [AW-1:0] src_q, dst_q;
  logic          u16_q;
  logic [WW-1:0] nw_q, wcnt;
  logic          part;
  logic [15:0]   hold;

  wire           rd        = (st == S_RD);
  wire           wr        = (st == S_WR);
  wire [AW-1:0]  base      = wr ? dst_q : src_q;
  wire           split     = u16_q & base[0];
  wire           last_clk  = (wcnt == nw_q);
  wire           last_part = !split || part;
  wire [7:0]     rbyte     = bus_be_o[1] ? bus_rdata_i[15:8] : bus_rdata_i[7:0];
  wire [7:0]     wbyte     = (split && part) ? hold[15:8] : hold[7:0];

  assign bus_req_o   = rd | wr;
  assign bus_we_o    = wr;
  assign bus_addr_o  = base + AW'(part);
  assign bus_wdata_o = (u16_q && !dst_q[0]) ? hold : {wbyte, wbyte};
  assign rd_data_o   = hold;
  assign done_o      = (st == S_DONE);

  always_comb begin
    if (!u16_q)       bus_be_o = base[0] ? 2'b10 : 2'b01;
    else if (!base[0]) bus_be_o = 2'b11;
    else              bus_be_o = part ? 2'b01 : 2'b10;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      src_q <= '0;
      dst_q <= '0;
      u16_q <= 1'b0;
      nw_q  <= '0;
      wcnt  <= '0;
      part  <= 1'b0;
      hold  <= '0;
    end else begin
      case (st)
        S_IDLE: if (start_i) begin
          src_q <= src_addr_i;
          dst_q <= dst_addr_i;
          u16_q <= unit16_i;
          nw_q  <= wait_i;
          wcnt  <= '0;
          part  <= 1'b0;
          st    <= S_RD;
        end
        S_RD, S_WR: begin
          if (!last_clk) begin
            wcnt <= wcnt + 1'b1;
          end else begin
            wcnt <= '0;
            if (rd) begin
              if (u16_q && !split) hold <= bus_rdata_i;
              else if (!u16_q)     hold <= {8'h00, rbyte};
              else if (!part)      hold[7:0] <= rbyte;
              else                 hold[15:8] <= rbyte;
            end
            if (last_part) begin
              part <= 1'b0;
              st   <= rd ? S_WR : S_DONE;
            end else begin
              part <= 1'b1;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dma_xfer_seq_chk.sv
module dma_xfer_seq_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_req_o,
  input logic          bus_we_o,
  input logic [AW-1:0] bus_addr_o,
  input logic [1:0]    bus_be_o,
  input logic          done_o
);
  AST_WE_ONLY_IN_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we_o |-> bus_req_o); // R1
  AST_NO_READ_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_o && bus_we_o) |=> !(bus_req_o && !bus_we_o)); // R1
  AST_ODD_ADDR_ODD_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_o && bus_addr_o[0]) |-> (bus_be_o == 2'b10)); // R3
  AST_LANE_PRESENT: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_o |-> (bus_be_o != 2'b00)); // R5
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R7
  AST_DONE_OFF_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !bus_req_o); // R7
  AST_DONE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> $past(bus_we_o)); // R7
  AST_NO_CYCLE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !bus_req_o); // R8
endmodule

bind dma_xfer_seq dma_xfer_seq_chk #(.AW(AW)) u_chk (.*);

// File: tb/dma_xfer_seq_tb.sv
module dma_xfer_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [15:0] src_addr_i = '0, dst_addr_i = '0;
  logic        unit16_i = 1'b0;
  logic [1:0]  wait_i = '0;
  logic        bus_req_o, bus_we_o, done_o;
  logic [15:0] bus_addr_o, bus_wdata_o, rd_data_o;
  logic [1:0]  bus_be_o;
  logic [15:0] bus_rdata_i = '0;

  dma_xfer_seq u_dut (.*);

  always #10 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  logic [7:0] mem [256];
  logic [7:0] m0  [256];

  int          cur_n;
  int          nseg, idx, done_cnt, clk_no, last_req_clk, done_clk;
  logic [15:0] seg_addr [16];
  logic [1:0]  seg_be   [16];
  logic        seg_we   [16];
  int          seg_len  [16];
  logic        prev_req;
  logic [18:0] prev_key;

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      logic [18:0] key;
      logic [7:0]  a;
      logic [15:0] good;
      clk_no++;
      if (done_o) begin done_cnt++; done_clk = clk_no; end
      if (bus_req_o) begin
        key = {bus_we_o, bus_addr_o, bus_be_o};
        if (!prev_req || key != prev_key) begin
          idx = 0;
          if (nseg < 16) begin
            seg_addr[nseg] = bus_addr_o;
            seg_be[nseg] = bus_be_o;
            seg_we[nseg] = bus_we_o;
          end
          nseg++;
        end else idx++;
        if (nseg <= 16) seg_len[nseg-1] = idx + 1;
        last_req_clk = clk_no;
        a = bus_addr_o[7:0];
        good = {mem[{a[7:1], 1'b1}], mem[{a[7:1], 1'b0}]};
        bus_rdata_i = (idx == cur_n) ? good : ~good;
        if (bus_we_o && idx == cur_n) begin
          if (bus_be_o[0]) mem[{a[7:1], 1'b0}] = bus_wdata_o[7:0];
          if (bus_be_o[1]) mem[{a[7:1], 1'b1}] = bus_wdata_o[15:8];
        end
        prev_key = key;
      end
      prev_req = bus_req_o;
    end
  end

  task automatic xfer(input bit u16, input logic [15:0] src, input logic [15:0] dst,
                      input int n, input bit poke_busy, input bit poke_done, input int seed);
    logic [15:0] e_addr [4];
    logic [1:0]  e_be   [4];
    logic        e_we   [4];
    int          ne;
    bit          seen;
    logic [15:0] exp_rd;
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'(i * 37 + seed * 11 + 5);
      m0[i]  = mem[i];
    end
    ne = 0;
    for (int side = 0; side < 2; side++) begin
      logic [15:0] b;
      b = side ? dst : src;
      if (!u16) begin
        e_addr[ne] = b; e_be[ne] = b[0] ? 2'b10 : 2'b01; e_we[ne] = 1'(side); ne++;
      end else if (!b[0]) begin
        e_addr[ne] = b; e_be[ne] = 2'b11; e_we[ne] = 1'(side); ne++;
      end else begin
        e_addr[ne] = b;     e_be[ne] = 2'b10; e_we[ne] = 1'(side); ne++;
        e_addr[ne] = b + 1; e_be[ne] = 2'b01; e_we[ne] = 1'(side); ne++;
      end
    end
    @(negedge clk);
    nseg = 0; done_cnt = 0; cur_n = n; done_clk = 0; last_req_clk = 0;
    src_addr_i = src; dst_addr_i = dst; unit16_i = u16; wait_i = 2'(n); start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    if (poke_busy) begin
      @(negedge clk);
      src_addr_i = 16'h0040; dst_addr_i = 16'h00C0; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    seen = 0;
    for (int t = 0; t < 100 && !seen; t++) begin
      if (done_o) seen = 1;
      else @(negedge clk);
    end
    if (poke_done && seen) begin
      src_addr_i = 16'h0040; dst_addr_i = 16'h00C0; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    repeat (12) @(negedge clk);

    chk(nseg == ne, $sformatf("R2/R3/R4/R5 cycle count u16=%0d s=%0h d=%0h", u16, src, dst), nseg, ne);
    if (nseg == ne) begin
      for (int k = 0; k < ne; k++) begin
        chk(seg_addr[k] == e_addr[k], $sformatf("R3 addr seg %0d", k), seg_addr[k], e_addr[k]);
        chk(seg_be[k] == e_be[k], $sformatf("R2/R3/R5 lanes seg %0d", k), seg_be[k], e_be[k]);
        chk(seg_we[k] == e_we[k], $sformatf("R1 direction seg %0d", k), seg_we[k], e_we[k]);
        chk(seg_len[k] == n + 1, $sformatf("R6 length seg %0d n=%0d", k, n), seg_len[k], n + 1);
      end
    end
    chk(done_cnt == 1, "R7/R8 done pulse count", done_cnt, 1);
    chk(done_clk == last_req_clk + 1, "R7 done timing", done_clk, last_req_clk + 1);
    chk(mem[dst[7:0]] == m0[src[7:0]], "R3/R5/R6 dest low byte", mem[dst[7:0]], m0[src[7:0]]);
    if (u16) begin
      chk(mem[8'(dst + 1)] == m0[8'(src + 1)], "R3/R6 dest high byte",
          mem[8'(dst + 1)], m0[8'(src + 1)]);
      exp_rd = {m0[8'(src + 1)], m0[src[7:0]]};
    end else begin
      chk(mem[8'(dst + 1)] == m0[8'(dst + 1)], "R5 neighbour byte untouched",
          mem[8'(dst + 1)], m0[8'(dst + 1)]);
      exp_rd = {8'h00, m0[src[7:0]]};
    end
    chk(mem[8'(dst - 1)] == m0[8'(dst - 1)], "R5 byte below dest untouched",
        mem[8'(dst - 1)], m0[8'(dst - 1)]);
    chk(mem[8'h40] == m0[8'h40] && mem[8'hC0] == m0[8'hC0], "R8 ignored start left memory alone",
        mem[8'hC0], m0[8'hC0]);
    chk(rd_data_o == exp_rd, "R9 holding register", rd_data_o, exp_rd);
    chk(!bus_req_o && !done_o, "R8 idle after transfer", bus_req_o, 0);
  endtask

  initial begin
    clk_no = 0; nseg = 0; done_cnt = 0; prev_req = 0; prev_key = '0; idx = 0; cur_n = 0;
    repeat (3) @(negedge clk);
    chk(!bus_req_o && !done_o, "R10 reset outputs", {bus_req_o, done_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!bus_req_o && !done_o, "R10 after reset release", {bus_req_o, done_o}, 0);
    for (int u = 0; u < 2; u++)
      for (int s = 0; s < 2; s++)
        for (int d = 0; d < 2; d++)
          for (int n = 0; n < 4; n++)
            xfer(1'(u), 16'h0010 + 16'(s) + 16'(4 * n), 16'h0080 + 16'(d) + 16'(4 * n),
                 n, 1'(n % 2), 1'((n + s) % 2), u * 16 + s * 8 + d * 4 + n);
    xfer(1'b1, 16'h00FF, 16'h0085, 2, 1'b0, 1'b1, 99);
    xfer(1'b0, 16'h0031, 16'h00A0, 3, 1'b1, 1'b1, 77);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule